// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block sits in front of the write engine of a paged nonvolatile memory and watches every byte-load event, each one an address and a data byte. It holds a software write-protect flag and recognises two command patterns in the load stream. The first is a three-step prefix that arms protection and, while protection is active, also unlocks one page write. The second is a six-step pattern that removes protection. For each load it tells the engine whether the byte is to be stored or thrown away. It also asks the engine to run the programming timer, including for discarded bytes and for a command that carries no data.

Command bytes are never stored. A change to the protect flag is only recorded as pending when its command completes. The flag itself changes at the end of the next programming period, which the engine reports on `prog_done`. Command bytes must arrive within the byte-load window (`WIN_CYC` clock cycles from the previous load); a longer gap drops the matcher back to idle. A load that does not fit the expected next step also returns the matcher to idle, and that load is then treated as an ordinary write.

Top module: `wp_seq_detector`

## Requirements
- R1: After reset `wp_on` is 0. An ordinary load while unprotected gives `ld_store`=1, `ld_discard`=0 and `prog_start`=1 in the cycle of the strobe.
- R2: The enable prefix is three loads: data 8'hAA at address 15'h5555, then 8'h55 at 15'h2AAA, then 8'hA0 at 15'h5555. None of the three is stored or discarded. The third asserts `prog_start`.
- R3: `wp_on` changes only in the cycle after a `prog_done` pulse, when a completed command is pending. This holds even if no data byte follows the command.
- R4: While protected, data loads that follow the prefix within the window are stored (`ld_store`=1). The protect flag stays set after the programming period ends.
- R5: While protected, a load that has no prefix gives `ld_discard`=1 and `prog_start`=1, with `ld_store`=0.
- R6: The disable sequence is 8'hAA@15'h5555, 8'h55@15'h2AAA, 8'h80@15'h5555, 8'hAA@15'h5555, 8'h55@15'h2AAA, 8'h20@15'h5555. Its sixth load asserts `prog_start`. Data loads that follow it are stored. `wp_on` clears after the next `prog_done`.
- R7: A load that does not match the expected next step returns the matcher to idle. That load is judged as an ordinary write under the current protect state: stored if unprotected, discarded if protected.
- R8: A load that arrives up to `WIN_CYC` cycles after the previous load continues a sequence. A load that arrives later starts fresh and is judged as an ordinary write.
- R9: Inside an unlocked write, a load to a command address with command data is stored as data.
- R10: When a load and `prog_done` fall in the same cycle, two rules apply. The load is judged under the protect state from before that cycle. A command completed by that load stays pending until a later `prog_done`.
- R11: An unlocked write ends at `prog_done`. After that, a load while protected is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ld_stb | input | 1 | One-cycle byte-load strobe |
| ld_addr | input | 15 | Address of the load |
| ld_data | input | 8 | Data of the load |
| prog_done | input | 1 | Pulse at the end of a programming period |
| ld_store | output | 1 | This load is written to the array |
| ld_discard | output | 1 | This load is thrown away (protected) |
| prog_start | output | 1 | Run the programming timer for this load |
| wp_on | output | 1 | Software write-protect flag |

## Verification
The delicate case is a byte load that coincides with the end-of-programming pulse. In that cycle the protect flag updates, an unlocked page closes, and the load itself is classified, all at once. The bench provokes this case twice. In the first, the final enable byte arrives together with `prog_done`; the bench checks that `wp_on` stays clear and sets only on the following pulse. In the second, an ordinary load arrives together with the `prog_done` that applies a pending disable. That load must still be discarded, and `wp_on` must read 0 in the next cycle.

// File: rtl/wp_seq_detector.sv
module wp_seq_detector #(
  parameter int AW = 15,
  parameter int DW = 8,
  parameter int WIN_CYC = 7500,
  parameter logic [AW-1:0] ADR_A = 15'h5555,
  parameter logic [AW-1:0] ADR_B = 15'h2AAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_stb,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          prog_done,
  output logic          ld_store,
  output logic          ld_discard,
  output logic          prog_start,
  output logic          wp_on
);
  localparam int CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] GAP_LAST = CW'(WIN_CYC - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_S1, ST_S2, ST_UNLK, ST_D3, ST_D4, ST_D5} st_t;

  st_t st_q, st_d;
  logic [CW-1:0] gap_q;
  logic wp_q, pen_en_q, pen_dis_q;
  logic step, fin_en, fin_dis, data_ld;

  wire at_a  = ld_addr == ADR_A;
  wire at_b  = ld_addr == ADR_B;
  wire is_aa = at_a && ld_data == DW'(8'hAA);
  wire is_55 = at_b && ld_data == DW'(8'h55);
  wire is_a0 = at_a && ld_data == DW'(8'hA0);
  wire is_80 = at_a && ld_data == DW'(8'h80);
  wire is_20 = at_a && ld_data == DW'(8'h20);

  always_comb begin
    step = 1'b0;
    fin_en = 1'b0;
    fin_dis = 1'b0;
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (is_aa) begin step = 1'b1; st_d = ST_S1; end
      ST_S1:   if (is_55) begin step = 1'b1; st_d = ST_S2; end
      ST_S2: begin
        if (is_a0) begin step = 1'b1; fin_en = 1'b1; st_d = ST_UNLK; end
        else if (is_80) begin step = 1'b1; st_d = ST_D3; end
      end
      ST_D3:   if (is_aa) begin step = 1'b1; st_d = ST_D4; end
      ST_D4:   if (is_55) begin step = 1'b1; st_d = ST_D5; end
      ST_D5:   if (is_20) begin step = 1'b1; fin_dis = 1'b1; st_d = ST_UNLK; end
      default: ;
    endcase
    if (!ld_stb) begin
      step = 1'b0;
      fin_en = 1'b0;
      fin_dis = 1'b0;
      st_d = st_q;
      if (st_q != ST_IDLE && gap_q == GAP_LAST) st_d = ST_IDLE;
    end else if (!step && st_q != ST_UNLK) begin
      st_d = ST_IDLE;
    end
    if (prog_done && st_q == ST_UNLK) st_d = ST_IDLE;
  end

  assign data_ld    = ld_stb && !step;
  assign ld_store   = data_ld && (st_q == ST_UNLK || !wp_q);
  assign ld_discard = data_ld && st_q != ST_UNLK && wp_q;
  assign prog_start = data_ld || fin_en || fin_dis;
  assign wp_on      = wp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      gap_q     <= '0;
      wp_q      <= 1'b0;
      pen_en_q  <= 1'b0;
      pen_dis_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (ld_stb) gap_q <= '0;
      else if (gap_q != GAP_LAST) gap_q <= gap_q + 1'b1;
      pen_en_q  <= fin_en  || (pen_en_q  && !prog_done && !fin_dis);
      pen_dis_q <= fin_dis || (pen_dis_q && !prog_done && !fin_en);
      if (prog_done) begin
        if (pen_en_q) wp_q <= 1'b1;
        else if (pen_dis_q) wp_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wp_seq_detector_chk.sv
module wp_seq_detector_chk (
  input logic clk,
  input logic rst_n,
  input logic ld_stb,
  input logic prog_done,
  input logic ld_store,
  input logic ld_discard,
  input logic prog_start,
  input logic wp_on
);
  assert_quiet_no_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_stb |-> (!ld_store && !ld_discard && !prog_start));

  assert_wp_moves_on_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_done |=> $stable(wp_on));

  assert_discard_only_protected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_discard |-> (wp_on && prog_start));

  assert_store_starts_timer_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_store |-> (prog_start && !ld_discard));

  assert_unprot_never_discards_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_on |-> !ld_discard);
endmodule

bind wp_seq_detector wp_seq_detector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .prog_done(prog_done),
  .ld_store(ld_store), .ld_discard(ld_discard), .prog_start(prog_start), .wp_on(wp_on)
);

// File: tb/sim_wp_seq_detector.sv
`timescale 1ns/1ps
module sim_wp_seq_detector;
  localparam int W = 16;
  logic clk = 0, rst_n = 0, ld_stb = 0, prog_done = 0;
  logic [14:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic ld_store, ld_discard, prog_start, wp_on;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  wp_seq_detector #(.WIN_CYC(W)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_addr(ld_addr), .ld_data(ld_data),
    .prog_done(prog_done), .ld_store(ld_store), .ld_discard(ld_discard),
    .prog_start(prog_start), .wp_on(wp_on));

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // exp = {store, discard, start}
  task automatic ld(input logic [14:0] a, input logic [7:0] d, input logic [2:0] exp,
                    input bit with_done, input string tag);
    logic [2:0] act;
    @(negedge clk);
    ld_stb = 1; ld_addr = a; ld_data = d; prog_done = with_done;
    #2;
    act = {ld_store, ld_discard, prog_start};
    chk(act == exp, tag, {5'b0, act}, {5'b0, exp});
    @(posedge clk); #1;
    ld_stb = 0; prog_done = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic done_pulse();
    @(negedge clk); prog_done = 1;
    @(posedge clk); #1; prog_done = 0;
  endtask

  task automatic chk_wp(input logic e, input string tag);
    @(negedge clk);
    chk(wp_on == e, tag, {7'b0, wp_on}, {7'b0, e});
  endtask

  task automatic t_reset();
    chk_wp(0, "R1 reset wp_on");
    ld(15'h0100, 8'h12, 3'b101, 0, "R1 ordinary load stored");
  endtask

  task automatic t_mismatch_unprot();
    ld(15'h5555, 8'hAA, 3'b000, 0, "R7 step1 is command");
    ld(15'h2AAA, 8'h56, 3'b101, 0, "R7 mismatch stored as ordinary");
    ld(15'h2AAA, 8'h55, 3'b101, 0, "R7 matcher back at idle");
  endtask

  task automatic t_gap_abort();
    ld(15'h5555, 8'hAA, 3'b000, 0, "R8 step1");
    idle(W);
    ld(15'h2AAA, 8'h55, 3'b101, 0, "R8 late step2 judged ordinary");
  endtask

  task automatic t_enable();
    ld(15'h5555, 8'hAA, 3'b000, 0, "R2 enable step1");
    idle(W - 1);
    ld(15'h2AAA, 8'h55, 3'b000, 0, "R8 step2 at window edge");
    idle(W - 1);
    ld(15'h5555, 8'hA0, 3'b001, 0, "R2 enable step3 starts timer");
    idle(3);
    chk_wp(0, "R3 wp waits for prog_done");
    done_pulse();
    chk_wp(1, "R3 wp set after prog_done");
  endtask

  task automatic t_prot_noprefix();
    ld(15'h0200, 8'h33, 3'b011, 0, "R5 protected load discarded");
    done_pulse();
    chk_wp(1, "R5 wp stays set");
  endtask

  task automatic t_prot_prefix();
    ld(15'h5555, 8'hAA, 3'b000, 0, "R4 prefix1");
    ld(15'h2AAA, 8'h55, 3'b000, 0, "R4 prefix2");
    ld(15'h5555, 8'hA0, 3'b001, 0, "R4 prefix3");
    ld(15'h0300, 8'h44, 3'b101, 0, "R4 unlocked data stored");
    ld(15'h5555, 8'hAA, 3'b101, 0, "R9 command address stored as data");
    done_pulse();
    chk_wp(1, "R4 wp still set after page");
    ld(15'h0300, 8'h77, 3'b011, 0, "R11 session closed by prog_done");
    done_pulse();
  endtask

  task automatic t_mismatch_prot();
    ld(15'h5555, 8'hAA, 3'b000, 0, "R7 prot step1");
    ld(15'h2AAA, 8'h55, 3'b000, 0, "R7 prot step2");
    ld(15'h5555, 8'h99, 3'b011, 0, "R7 prot mismatch discarded");
    done_pulse();
  endtask

  task automatic t_disable();
    ld(15'h5555, 8'hAA, 3'b000, 0, "R6 dis1");
    ld(15'h2AAA, 8'h55, 3'b000, 0, "R6 dis2");
    ld(15'h5555, 8'h80, 3'b000, 0, "R6 dis3");
    ld(15'h5555, 8'hAA, 3'b000, 0, "R6 dis4");
    ld(15'h2AAA, 8'h55, 3'b000, 0, "R6 dis5");
    ld(15'h5555, 8'h20, 3'b001, 0, "R6 dis6 starts timer");
    ld(15'h0400, 8'h5A, 3'b101, 0, "R6 data after disable stored");
    chk_wp(1, "R6 wp held until prog_done");
    done_pulse();
    chk_wp(0, "R6 wp cleared");
    ld(15'h0401, 8'h5B, 3'b101, 0, "R6 ordinary stored after disable");
  endtask

  task automatic t_overlap();
    ld(15'h5555, 8'hAA, 3'b000, 0, "R10 en1");
    ld(15'h2AAA, 8'h55, 3'b000, 0, "R10 en2");
    ld(15'h5555, 8'hA0, 3'b001, 1, "R10 en3 with prog_done");
    chk_wp(0, "R10 same-cycle done not applied");
    done_pulse();
    chk_wp(1, "R10 pending applied on next done");
    ld(15'h5555, 8'hAA, 3'b000, 0, "R10 dis1");
    ld(15'h2AAA, 8'h55, 3'b000, 0, "R10 dis2");
    ld(15'h5555, 8'h80, 3'b000, 0, "R10 dis3");
    ld(15'h5555, 8'hAA, 3'b000, 0, "R10 dis4");
    ld(15'h2AAA, 8'h55, 3'b000, 0, "R10 dis5");
    ld(15'h5555, 8'h20, 3'b001, 0, "R10 dis6");
    idle(W + 1);
    ld(15'h0500, 8'h11, 3'b011, 1, "R10 load with done uses old state");
    chk_wp(0, "R10 disable applied");
  endtask

  initial begin
    #200;
    @(negedge clk); rst_n = 1;
    t_reset();
    t_mismatch_unprot();
    t_gap_abort();
    t_enable();
    t_prot_noprefix();
    t_prot_prefix();
    t_mismatch_prot();
    t_disable();
    t_overlap();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule